// File: doc/BRIEF.md
# Timer Clock-Source and Stop-Mode Gating Controller

This block controls two timer channels. Channel 0 is a periodic real-time tick counter and channel 1 is a watchdog counter. The block keeps the control state for each channel and drives the signals that the counters and the clock multiplexers next to it use. Each channel has a clock-source bit and a stop-enable bit. The clock-source bit picks either the internal RC clock (0) or the external oscillator clock (1). The stop-enable bit lets the channel keep counting while the chip is in pseudo-stop.

The external clock can be selected only while the oscillator reports that it is stable. If that status is lost, the source bit falls back to the internal clock without any software action. Whenever a channel's source bit changes value, the block sends that channel a one-cycle restart pulse so its timeout period starts again. The block also drives a clock-enable per channel. In run mode the enable is high. In pseudo-stop the enable stays high only for a channel that has both its stop-enable bit set and the external clock selected. In full stop both enables are low. A counter whose enable is low keeps its current value, because a drop in the enable never causes a restart.

Software updates the control bits through a valid/ready write port. One transfer carries the bits for both channels. `wr_ready` is low while reset is asserted and from the first clock after reset onward it is always high, so the port never applies back-pressure. A transfer completes on every clock edge where `wr_valid` and `wr_ready` are both high. The oscillator status input is asynchronous and passes through a synchronizer of `SYNC_STAGES` flops before the block uses it.

Top module: `tmr_clksrc_ctrl`

## Requirements
- R1: After reset, `clk_sel` is 0 for both channels, both stop-enable bits are 0, `restart` is 0, and `clk_en` is 1 for both channels (run mode).
- R2: `wr_ready` is low during reset and high from then on. A transfer with the synchronized oscillator status high loads `wr_data[2i]` into `clk_sel[i]`; the new value appears one cycle after the transfer edge.
- R3: A transfer that writes 1 to a source bit while the synchronized oscillator status is low leaves that bit at 0 and produces no restart.
- R4: When `osc_good` falls, both source bits are 0 by the edge `SYNC_STAGES`+1 after the fall. Each channel whose bit was 1 gets a restart pulse in that same cycle.
- R5: `restart[i]` is high for exactly the cycle in which `clk_sel[i]` has just taken a new value. Writing the value a bit already holds produces no pulse.
- R6: While `pstop_req`=1 and `stop_req`=0, `clk_en[i]` is the AND of the channel's stop-enable bit (`wr_data[2i+1]`) and its `clk_sel[i]`.
- R7: While `stop_req`=1, both enables are 0, whatever the control bits and `pstop_req` are.
- R8: While `stop_req`=0 and `pstop_req`=0, both enables are 1.
- R9: Channel 0 uses `wr_data[1:0]` and channel 1 uses `wr_data[3:2]`. A transfer updates both channels in the same cycle, and a change on one channel never pulses the other channel's restart.
- R10: Entering or leaving stop or pseudo-stop causes no restart and does not change `clk_sel`, so a gated counter keeps its value.
- R11: With `wr_valid` low, any value on `wr_data` leaves all control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write transfer offered |
| wr_ready | output | 1 | Write port accepting (high after reset) |
| wr_data | input | 2*NUM_CH | Per channel i: bit 2i source, bit 2i+1 stop-enable |
| osc_good | input | 1 | External oscillator stable (asynchronous) |
| stop_req | input | 1 | Full stop mode active |
| pstop_req | input | 1 | Pseudo-stop mode active |
| clk_sel | output | NUM_CH | Selected source per channel (1 = oscillator) |
| clk_en | output | NUM_CH | Counter clock enable per channel |
| restart | output | NUM_CH | One-cycle timeout restart per channel |

## Verification
The assertions assume that `stop_req` and `pstop_req` are synchronous to `clk`. They also check the oscillator guard against the synchronized status inside the block, not against the raw pin, because the raw pin leads the guard by the length of the synchronizer. The bench changes `osc_good` only at falling clock edges. After raising it, the bench waits longer than the synchronizer depth before it writes, so that every write meets a settled status. It also changes the mode inputs only at falling edges, with no write pending, so that any restart that appears can come only from a mode change.

// File: rtl/tmr_clksrc_pkg.sv
package tmr_clksrc_pkg;
  localparam int unsigned CFG_BITS = 2;
  localparam int unsigned CH_TICK  = 0;
  localparam int unsigned CH_WDOG  = 1;

  typedef struct packed {
    logic stop_en;
    logic sel;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_PSTOP = 2'd1,
    MODE_STOP  = 2'd2
  } pwr_mode_e;

  function automatic pwr_mode_e decode_mode(input logic stop, input logic pstop);
    if (stop)       return MODE_STOP;
    else if (pstop) return MODE_PSTOP;
    else            return MODE_RUN;
  endfunction
endpackage

// File: rtl/tmr_clksrc_sync.sv
module tmr_clksrc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
    end else begin : g_chain
      logic [STAGES-1:0] flops;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flops <= '0;
        else if (STAGES == 1) flops <= async_in;
        else flops <= {flops[STAGES-2:0], async_in};
      end
      assign sync_out = flops[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tmr_clksrc_chan.sv
module tmr_clksrc_chan
  import tmr_clksrc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_fire,
  input  chan_cfg_t wr_cfg,
  input  logic      osc_ok,
  output logic      sel,
  output logic      stop_en,
  output logic      restart
);
  logic sel_q, stop_en_q, restart_q;
  logic sel_d, stop_en_d;

  always_comb begin
    sel_d     = sel_q;
    stop_en_d = stop_en_q;
    if (wr_fire) begin
      stop_en_d = wr_cfg.stop_en;
      sel_d     = wr_cfg.sel;
    end
    if (!osc_ok) sel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      stop_en_q <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      sel_q     <= sel_d;
      stop_en_q <= stop_en_d;
      restart_q <= sel_d ^ sel_q;
    end
  end

  assign sel     = sel_q;
  assign stop_en = stop_en_q;
  assign restart = restart_q;
endmodule

// File: rtl/tmr_clksrc_gate.sv
module tmr_clksrc_gate
  import tmr_clksrc_pkg::*;
(
  input  pwr_mode_e mode,
  input  logic      sel,
  input  logic      stop_en,
  output logic      en
);
  always_comb begin
    unique case (mode)
      MODE_RUN:   en = 1'b1;
      MODE_PSTOP: en = stop_en & sel;
      default:    en = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_clksrc_ctrl.sv
module tmr_clksrc_ctrl
  import tmr_clksrc_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [CFG_BITS*NUM_CH-1:0] wr_data,
  input  logic                       osc_good,
  input  logic                       stop_req,
  input  logic                       pstop_req,
  output logic [NUM_CH-1:0]          clk_sel,
  output logic [NUM_CH-1:0]          clk_en,
  output logic [NUM_CH-1:0]          restart
);
  logic      ready_q;
  logic      osc_ok;
  logic      wr_fire;
  pwr_mode_e mode;
  logic [NUM_CH-1:0] stop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign wr_ready = ready_q;
  assign wr_fire  = wr_valid & ready_q;
  assign mode     = decode_mode(stop_req, pstop_req);

  tmr_clksrc_sync #(.STAGES(SYNC_STAGES)) u_osc_sync (
    .clk(clk), .rst_n(rst_n), .async_in(osc_good), .sync_out(osc_ok)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      chan_cfg_t cfg;
      assign cfg = chan_cfg_t'(wr_data[CFG_BITS*i +: CFG_BITS]);

      tmr_clksrc_chan u_chan (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_cfg(cfg),
        .osc_ok(osc_ok), .sel(clk_sel[i]), .stop_en(stop_en[i]),
        .restart(restart[i])
      );

      tmr_clksrc_gate u_gate (
        .mode(mode), .sel(clk_sel[i]), .stop_en(stop_en[i]), .en(clk_en[i])
      );
    end
  endgenerate
endmodule

// File: rtl/tmr_clksrc_ctrl_chk.sv
module tmr_clksrc_ctrl_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [2*NUM_CH-1:0] wr_data,
  input logic              osc_ok,
  input logic              stop_req,
  input logic              pstop_req,
  input logic [NUM_CH-1:0] clk_sel,
  input logic [NUM_CH-1:0] clk_en,
  input logic [NUM_CH-1:0] restart
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R7
  p_full_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (clk_en == '0));
  // R8
  p_run_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_req && !pstop_req) |-> (clk_en == '1));

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ck
      // R5
      p_restart_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (restart[i] == (clk_sel[i] != $past(clk_sel[i]))));
      // R3
      p_sel_guarded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(clk_sel[i])) |->
          ($past(osc_ok) && $past(wr_valid) && $past(wr_ready) && $past(wr_data[2*i])));
      // R4
      p_osc_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(osc_ok)) |-> !clk_sel[i]);
      // R6
      p_pstop_needs_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pstop_req && !stop_req && !clk_sel[i]) |-> !clk_en[i]);
    end
  endgenerate
endmodule

bind tmr_clksrc_ctrl tmr_clksrc_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .osc_ok(osc_ok), .stop_req(stop_req),
  .pstop_req(pstop_req), .clk_sel(clk_sel), .clk_en(clk_en),
  .restart(restart)
);

// File: tb/tmr_clksrc_ctrl_test.sv
module tmr_clksrc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [3:0] wr_data = '0;
  logic       osc_good = 1'b0;
  logic       stop_req = 1'b0;
  logic       pstop_req = 1'b0;
  logic [1:0] clk_sel, clk_en, restart;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_clksrc_ctrl #(.NUM_CH(2), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .osc_good(osc_good), .stop_req(stop_req),
    .pstop_req(pstop_req), .clk_sel(clk_sel), .clk_en(clk_en),
    .restart(restart)
  );

  task automatic check(input string req, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // one transfer; returns at the negedge after the accepting edge
  task automatic write_cfg(input logic [3:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset();
    step(1);
    check("R1", "clk_sel in reset", {2'b0, clk_sel}, 4'b0000);
    check("R1", "restart in reset", {2'b0, restart}, 4'b0000);
    check("R1", "clk_en in reset",  {2'b0, clk_en},  4'b0011);
    check("R2", "wr_ready in reset", {3'b0, wr_ready}, 4'b0000);
    rst_n = 1'b1;
    step(1);
    check("R2", "wr_ready after reset", {3'b0, wr_ready}, 4'b0001);
  endtask

  task automatic t_blocked_select();
    write_cfg(4'b1111);
    check("R3", "sel with osc low", {2'b0, clk_sel}, 4'b0000);
    check("R3", "no restart", {2'b0, restart}, 4'b0000);
    pstop_req = 1'b1;
    step(1);
    check("R6", "pstop with sel 0", {2'b0, clk_en}, 4'b0000);
    pstop_req = 1'b0;
    step(1);
  endtask

  task automatic t_select_write();
    osc_good = 1'b1;
    step(4);
    write_cfg(4'b0001);
    check("R2", "sel loaded", {2'b0, clk_sel}, 4'b0001);
    check("R9", "restart only ch0", {2'b0, restart}, 4'b0001);
    step(1);
    check("R5", "restart one cycle", {2'b0, restart}, 4'b0000);
    write_cfg(4'b0001);
    check("R5", "same value no restart", {2'b0, restart}, 4'b0000);
    wr_data = 4'b1110;
    step(3);
    check("R11", "valid low ignored", {2'b0, clk_sel}, 4'b0001);
    write_cfg(4'b0100);
    check("R9", "both channels updated", {2'b0, clk_sel}, 4'b0010);
    check("R5", "restart on both changes", {2'b0, restart}, 4'b0011);
  endtask

  task automatic t_stop_modes();
    // ch0: sel=1 stop_en=1; ch1: sel=1 stop_en=0
    write_cfg(4'b0111);
    step(1);
    pstop_req = 1'b1;
    step(1);
    check("R6", "pstop gating", {2'b0, clk_en}, 4'b0001);
    check("R10", "no restart on pstop", {2'b0, restart}, 4'b0000);
    stop_req = 1'b1;
    step(1);
    check("R7", "full stop gating", {2'b0, clk_en}, 4'b0000);
    check("R10", "sel kept in stop", {2'b0, clk_sel}, 4'b0011);
    stop_req = 1'b0;
    pstop_req = 1'b0;
    step(1);
    check("R8", "run enables", {2'b0, clk_en}, 4'b0011);
    check("R10", "no restart on exit", {2'b0, restart}, 4'b0000);
  endtask

  task automatic t_osc_loss();
    write_cfg(4'b1111);
    step(1);
    osc_good = 1'b0;
    step(3);
    check("R4", "sel cleared on loss", {2'b0, clk_sel}, 4'b0000);
    check("R4", "restart on loss", {2'b0, restart}, 4'b0011);
    step(1);
    check("R4", "loss restart one cycle", {2'b0, restart}, 4'b0000);
    write_cfg(4'b1111);
    check("R3", "sel blocked after loss", {2'b0, clk_sel}, 4'b0000);
    pstop_req = 1'b1;
    step(1);
    check("R6", "stop_en kept but sel 0", {2'b0, clk_en}, 4'b0000);
    pstop_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_blocked_select();
    t_select_write();
    t_stop_modes();
    t_osc_loss();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule